// File: doc/BRIEF.md
# Latched-Address Latched-Data Eight-Way Bit Selector

The block picks one bit out of eight data inputs and presents it on two outputs, a true copy and an inverted copy. Both the data word and the three-bit select address pass through their own transparent holding stage. Each stage has an active-low open control. While a stage is open it passes its live input straight through. While it is closed it holds the value it captured at the last clock edge on which it was open.

Three output-enable inputs of mixed polarity decide whether the outputs are driven. The design is fully synchronous. Each holding stage is a clocked register plus a combinational bypass that is used while the stage is open. High impedance is not built from internal tri-states. It is reported on a drive flag that sits beside the output values, and a board-level wrapper can turn that flag into 'z'.

Top module: `latched_sel8`

## Requirements
- R1: While `dat_open_n` is 0, the selected bit comes from the live `dat_in` combinationally, in the same cycle.
- R2: While `dat_open_n` is 1, the data stage holds the word captured at the last rising clock edge at which `dat_open_n` was 0. Changes on `dat_in` then have no effect on the outputs.
- R3: While `sel_open_n` is 0, the live `sel_in` picks the bit combinationally.
- R4: While `sel_open_n` is 1, the address stage holds the address captured at the last rising clock edge at which `sel_open_n` was 0. Changes on `sel_in` then have no effect on the outputs.
- R5: Select encoding is binary. Address value k picks `dat_in` bit k, so 0 picks bit 0 and 7 picks bit 7.
- R6: `out_drive` is 1 only when `oe_a_n` = 0, `oe_b_n` = 0 and `oe_c` = 1. Any other combination gives 0.
- R7: Changing the output enables never alters the held data or the held address. The values seen after the outputs are enabled again are unchanged.
- R8: `y_n` is always the inverse of `y`.
- R9: Reset clears both holding stages to zero. With both stages closed after reset, `y` = 0 and `y_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of both holding stages |
| dat_in | input | 8 | Data word |
| dat_open_n | input | 1 | Data stage open control, active low |
| sel_in | input | 3 | Select address |
| sel_open_n | input | 1 | Address stage open control, active low |
| oe_a_n | input | 1 | Output enable, active low |
| oe_b_n | input | 1 | Output enable, active low |
| oe_c | input | 1 | Output enable, active high |
| y | output | 1 | Selected bit |
| y_n | output | 1 | Inverse of selected bit |
| out_drive | output | 1 | 1 when the outputs are driven, 0 when they are released |

## Verification
The main function is tried with both stages open and random words and addresses, which shows that selection is combinational. A walk over all eight addresses with one-hot and zero-hot words tells a binary decode apart from a reversed or shifted one. Two patterns separate the two storage paths. In the first, the address is frozen while the data keeps changing. In the second, the data is frozen while the address sweeps, which exposes swapped or shared open controls. The enables are then toggled through every combination while both stages hold, and the outputs must return unchanged. This tells a gating that touches storage apart from one that touches only the drive flag.

// File: rtl/latched_sel8.sv
module latched_sel8 #(
  parameter int N_IN  = 8,
  localparam int SEL_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  dat_in,
  input  logic             dat_open_n,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             sel_open_n,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             oe_c,
  output logic             y,
  output logic             y_n,
  output logic             out_drive
);

  logic [N_IN-1:0]  dat_q;
  logic [SEL_W-1:0] sel_q;
  logic [N_IN-1:0]  dat_eff;
  logic [SEL_W-1:0] sel_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q <= '0;
      sel_q <= '0;
    end else begin
      if (!dat_open_n) dat_q <= dat_in;
      if (!sel_open_n) sel_q <= sel_in;
    end
  end

  assign dat_eff   = dat_open_n ? dat_q : dat_in;
  assign sel_eff   = sel_open_n ? sel_q : sel_in;
  assign y         = dat_eff[sel_eff];
  assign y_n       = ~y;
  assign out_drive = ~oe_a_n & ~oe_b_n & oe_c;

  p_live_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_open_n && !sel_open_n) |-> (y == dat_in[sel_in]));

  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_open_n |=> $stable(dat_q));

  p_addr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_open_n && dat_open_n) |-> (y == dat_q[sel_in]));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_open_n |=> $stable(sel_q));

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_drive |-> (!oe_a_n && !oe_b_n && oe_c));

  p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
    y != y_n);

endmodule

// File: tb/latched_sel8_test.sv
module latched_sel8_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] dat_in = 0;
  logic dat_open_n = 1;
  logic [2:0] sel_in = 0;
  logic sel_open_n = 1;
  logic oe_a_n = 1, oe_b_n = 1, oe_c = 0;
  logic y, y_n, out_drive;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_dat;
  logic [2:0] m_sel;

  always #5 clk = ~clk;

  latched_sel8 uut (
    .clk(clk), .rst_n(rst_n), .dat_in(dat_in), .dat_open_n(dat_open_n),
    .sel_in(sel_in), .sel_open_n(sel_open_n), .oe_a_n(oe_a_n),
    .oe_b_n(oe_b_n), .oe_c(oe_c), .y(y), .y_n(y_n), .out_drive(out_drive)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dat <= 0;
      m_sel <= 0;
    end else begin
      if (!dat_open_n) m_dat <= dat_in;
      if (!sel_open_n) m_sel <= sel_in;
    end
  end

  task automatic compare(string tag);
    logic [7:0] d;
    int s;
    logic ey, edrv;
    d = dat_open_n ? m_dat : dat_in;
    s = sel_open_n ? int'(m_sel) : int'(sel_in);
    ey = d[s];
    edrv = (oe_a_n == 0) && (oe_b_n == 0) && (oe_c == 1);
    n_cmp++;
    if (y !== ey || y_n !== ~ey || out_drive !== edrv) begin
      n_bad++;
      $display("FAIL %s: y=%b y_n=%b drv=%b expected y=%b y_n=%b drv=%b",
               tag, y, y_n, out_drive, ey, ~ey, edrv);
    end
  endtask

  task automatic step(input logic [7:0] d, input logic de, input logic [2:0] s,
                      input logic se, input logic [2:0] oe, input string tag);
    @(negedge clk);
    dat_in = d; dat_open_n = de; sel_in = s; sel_open_n = se;
    oe_a_n = oe[2]; oe_b_n = oe[1]; oe_c = oe[0];
    #1 compare(tag);
  endtask

  localparam logic [2:0] OE_ON = 3'b001;

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    #1 compare("R9 reset");
    @(negedge clk); rst_n = 1;
    #1 compare("R9 after reset");
    for (int i = 0; i < 8; i++)
      step(8'h00, 1, 3'(i), 1, OE_ON, "R9 closed stages zero");

    for (int i = 0; i < 40; i++)
      step(8'($urandom), 0, 3'($urandom), 0, OE_ON, "R1 R3 live path");

    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 0, 3'(i), 0, OE_ON, "R5 one-hot select");
      step(~8'(1 << i), 0, 3'(i), 0, OE_ON, "R5 zero-hot select");
    end

    step(8'h00, 0, 3'd5, 0, OE_ON, "R4 load addr");
    for (int i = 0; i < 30; i++)
      step(8'($urandom), 0, 3'($urandom), 1, OE_ON, "R4 addr held data live");

    step(8'hA5, 0, 3'd0, 0, OE_ON, "R2 load data");
    for (int i = 0; i < 30; i++)
      step(8'($urandom), 1, 3'(i), 0, OE_ON, "R2 data held addr live");

    held = 8'h3C;
    step(held, 0, 3'd2, 0, OE_ON, "R7 load");
    step(8'hC3, 1, 3'd6, 1, OE_ON, "R7 both held");
    for (int k = 0; k < 8; k++)
      for (int r = 0; r < 3; r++)
        step(8'($urandom), 1, 3'($urandom), 1, 3'(k), "R6 R7 enable combos");
    step(8'h00, 1, 3'd0, 1, OE_ON, "R7 re-enabled value kept");
    for (int i = 0; i < 8; i++)
      step(8'hFF, 1, 3'(i), 0, OE_ON, "R7 held data intact");

    for (int i = 0; i < 20; i++)
      step(8'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
           3'($urandom), "R8 mixed");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule